// File: doc/BRIEF.md
# Presence-Detect Byte Store with Two-Wire Target Interface

This block is a 256-byte configuration store that a host reads and writes over a two-wire serial bus (I2C-style signalling on SCL and SDA). Three strap inputs give the low bits of the target's 7-bit bus address, so several modules can share one bus. A host sets an internal word pointer and then writes single bytes or reads one or more bytes in sequence. The pointer advances after every byte and wraps around at the end of the store.

The lower half of the store is treated as factory data. Bus writes to it are acknowledged but change nothing. The upper half is free for the host to write. A separate parallel load port writes any byte, including the protected half, and is how the factory image gets in. The block keeps a running 8-bit sum over bytes 0 to 62 and raises a flag whenever byte 63 disagrees with that sum.

SCL and SDA are sampled by the block clock, which must run well above the bus bit rate. SDA is returned as a pull-low enable. The line itself, with its pull-up, lies outside the block.

Top module: `spd_target`

## Requirements
- R1: The target acknowledges only the 7-bit address made of 1010 (most significant bits first) followed by `strap_i[2:0]`. Any other address gets no acknowledge, and the bytes that follow are ignored until the next START.
- R2: A bus write to an address from 0 to 127 (address bit 7 clear) is acknowledged but leaves the stored byte unchanged.
- R3: A bus write to an address from 128 to 255 stores the data byte at the pointer.
- R4: A write of one pointer byte, followed by a repeated START and a read address, returns the byte at that pointer. A read that comes with no pointer phase starts at the current pointer.
- R5: The pointer advances by one after each byte read or written, and wraps from 255 to 0.
- R6: `csum_err` is high exactly when byte 63 differs from the low 8 bits of the sum of bytes 0 to 62. It is updated on the clock edge that applies a load.
- R7: The load port writes any address. When a load and a bus write hit the same byte in one cycle, the load value is kept.
- R8: After reset, SDA is released, every byte reads 0 and `csum_err` is low.
- R9: A STOP returns the target to idle with SDA released. The target changes its SDA drive only after a falling SCL edge, or when it releases SDA on START or STOP. A host not-acknowledge ends a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High pulls SDA low |
| strap_i | input | 3 | Board straps, low address bits |
| load_we | input | 1 | Parallel load strobe |
| load_addr | input | 8 | Parallel load byte address |
| load_data | input | 8 | Parallel load byte value |
| csum_err | output | 1 | Byte 63 does not match the sum of bytes 0..62 |

## Verification
A parallel load and a bus write can land on the same upper-half byte in the same clock cycle. The bench provokes this by raising the load strobe, aimed at the bus write's target byte, on the falling SCL edge that ends the eighth data bit. It holds the strobe for exactly three clock cycles, so that the last load cycle coincides with the cycle in which the synchronised falling edge commits the bus write. A later bus read of that byte must return the load value and not the bus value.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_MACK
  } spd_state_e;
endpackage

// File: rtl/spd_pin_sync.sv
module spd_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {(STAGES+1){RST_VAL}};
    else        sh_q <= {sh_q[STAGES-1:0], d};
  end

  assign q    = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int CSUM_IDX = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          csum_err
);
  localparam int            DEPTH   = 1 << AW;
  localparam logic [AW-1:0] CSUM_AT = AW'(CSUM_IDX);

  logic [DW-1:0] mem_w [DEPTH];
  logic [DW-1:0] sum_q, sum_d;

  // Address bit AW-1 clear marks the protected half.
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [AW-1:0] GA = AW'(g);
    logic [DW-1:0] word_q, word_d;
    logic          word_en;

    always_comb begin
      word_en = 1'b0;
      word_d  = word_q;
      if (ld_we && (ld_addr == GA)) begin
        word_en = 1'b1;
        word_d  = ld_data;
      end else if (bus_we && (bus_addr == GA) && GA[AW-1]) begin
        word_en = 1'b1;
        word_d  = bus_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign mem_w[g] = word_q;
  end

  // Running sum: only loads below the checksum byte can move it.
  always_comb begin
    sum_d = sum_q;
    if (ld_we && (ld_addr < CSUM_AT))
      sum_d = sum_q - mem_w[ld_addr] + ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign csum_err = (sum_q != mem_w[CSUM_AT]);
  assign rd_data  = mem_w[rd_addr];

  assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr[AW-1] && !ld_we) |=>
      (mem_w[$past(bus_addr)] == $past(mem_w[bus_addr])));

  assert_upper_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1] && !ld_we) |=>
      (mem_w[$past(bus_addr)] == $past(bus_data)));

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> (mem_w[$past(ld_addr)] == $past(ld_data)));

  assert_sum_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_we |=> $stable(sum_q));
endmodule

// File: rtl/spd_bus_fsm.sv
module spd_bus_fsm
  import spd_pkg::*;
#(
  parameter int         AW      = 8,
  parameter int         STRAP_W = 3,
  parameter logic [3:0] DEV_ID  = 4'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_q,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_q,
  input  logic               sda_rise,
  input  logic               sda_fall,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               bus_we,
  output logic [AW-1:0]      ptr,
  output logic [BYTE_W-1:0]  wr_byte,
  output logic               sda_oe
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W);

  spd_state_e          st_q, st_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic [AW-1:0]       ptr_q, ptr_d;
  logic                oe_q, oe_d;
  logic                rnw_q, rnw_d;
  logic                start, stop, byte_done, addr_hit;

  assign start     = scl_q & sda_fall;
  assign stop      = scl_q & sda_rise;
  assign byte_done = (cnt_q == LAST);
  assign addr_hit  = (sh_q[BYTE_W-1:1] == {DEV_ID, strap});

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    oe_d   = oe_q;
    rnw_d  = rnw_q;
    bus_we = 1'b0;
    if (stop) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_q};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && byte_done) begin
            cnt_d = '0;
            if (st_q == ST_ADDR) begin
              if (addr_hit) begin
                oe_d  = 1'b1;
                rnw_d = sh_q[0];
                st_d  = ST_ADDR_ACK;
              end else begin
                st_d = ST_IDLE;
              end
            end else if (st_q == ST_PTR) begin
              ptr_d = AW'(sh_q);
              oe_d  = 1'b1;
              st_d  = ST_PTR_ACK;
            end else begin
              bus_we = 1'b1;
              ptr_d  = ptr_q + 1'b1;
              oe_d   = 1'b1;
              st_d   = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rnw_q) begin
              sh_d  = rd_data;
              ptr_d = ptr_q + 1'b1;
              oe_d  = ~rd_data[BYTE_W-1];
              cnt_d = '0;
              st_d  = ST_TX;
            end else begin
              oe_d = 1'b0;
              st_d = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = ST_WDATA;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (byte_done) begin
              oe_d  = 1'b0;
              cnt_d = '0;
              st_d  = ST_MACK;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_q) st_d = ST_IDLE;
          end else if (scl_fall) begin
            sh_d  = rd_data;
            ptr_d = ptr_q + 1'b1;
            oe_d  = ~rd_data[BYTE_W-1];
            cnt_d = '0;
            st_d  = ST_TX;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      oe_q  <= 1'b0;
      rnw_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      ptr_q <= ptr_d;
      oe_q  <= oe_d;
      rnw_q <= rnw_d;
    end
  end

  assign ptr     = ptr_q;
  assign wr_byte = sh_q;
  assign sda_oe  = oe_q;

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!sda_oe && (st_q == ST_IDLE)));

  assert_drive_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start && !stop) |=> $stable(sda_oe));

  assert_foreign_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ADDR) && scl_fall && byte_done && !start && !stop && !addr_hit)
      |=> (!sda_oe && (st_q == ST_IDLE)));

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_MACK) && scl_fall && !scl_rise && !start && !stop && (ptr_q == '1))
      |=> (ptr_q == '0));
endmodule

// File: rtl/spd_target.sv
module spd_target #(
  parameter int AW       = 8,
  parameter int STRAP_W  = 3,
  parameter int SYNC_N   = 2,
  parameter int CSUM_IDX = 63
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               load_we,
  input  logic [AW-1:0]      load_addr,
  input  logic [7:0]         load_data,
  output logic               csum_err
);
  logic       scl_q, scl_rise, scl_fall;
  logic       sda_q, sda_rise, sda_fall;
  logic       bus_we;
  logic [AW-1:0] ptr;
  logic [7:0] wr_byte, rd_data;

  spd_pin_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i),
    .q(scl_q), .rise(scl_rise), .fall(scl_fall)
  );

  spd_pin_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i),
    .q(sda_q), .rise(sda_rise), .fall(sda_fall)
  );

  spd_bus_fsm #(.AW(AW), .STRAP_W(STRAP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_q(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_q(sda_q), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .strap(strap_i), .rd_data(rd_data),
    .bus_we(bus_we), .ptr(ptr), .wr_byte(wr_byte), .sda_oe(sda_oe)
  );

  spd_store #(.AW(AW), .DW(8), .CSUM_IDX(CSUM_IDX)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_we(load_we), .ld_addr(load_addr), .ld_data(load_data),
    .bus_we(bus_we), .bus_addr(ptr), .bus_data(wr_byte),
    .rd_addr(ptr), .rd_data(rd_data), .csum_err(csum_err)
  );
endmodule

// File: tb/sim_spd_target.sv
module sim_spd_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic [2:0] strap;
  logic       load_we;
  logic [7:0] load_addr, load_data;
  logic       sda_oe, csum_err;
  wire        sda_line = sda_m & ~sda_oe;

  int total = 0;
  int fails = 0;
  logic [7:0] model [256];
  logic [7:0] rd_buf [8];

  bit         collide_arm = 1'b0;
  logic [7:0] collide_addr, collide_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .csum_err(csum_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_sum();
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 63; i++) s = s + model[i];
    return s;
  endfunction

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq(Q);
      scl_m = 1'b1; waitq(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1;
    if (collide_arm) begin
      load_we = 1'b1; load_addr = collide_addr; load_data = collide_data;
      waitq(3);
      load_we = 1'b0;
      waitq(Q - 3);
    end else begin
      waitq(Q);
    end
    scl_m = 1'b1; waitq(Q/2);
    ack = ~sda_line;
    waitq(Q/2);
    scl_m = 1'b0;
  endtask

  task automatic rbyte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(Q);
      scl_m = 1'b1; waitq(Q/2);
      b[i] = sda_line;
      waitq(Q/2);
      scl_m = 1'b0;
    end
    sda_m = nack; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    scl_m = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic rnw);
    return {4'b1010, strap, rnw};
  endfunction

  task automatic load(input logic [7:0] a, input logic [7:0] d);
    load_we = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] p, input logic [7:0] d, input string req);
    bit a0, a1, a2;
    i2c_start();
    wbyte(dev(1'b0), a0);
    wbyte(p, a1);
    wbyte(d, a2);
    i2c_stop();
    check({req, " write acks"}, {a0, a1, a2}, 3'b111);
    if (p[7]) model[p] = d;
  endtask

  task automatic bus_read(input logic [7:0] p, input int n, input string req);
    bit a0, a1, a2;
    logic [7:0] b;
    i2c_start();
    wbyte(dev(1'b0), a0);
    wbyte(p, a1);
    i2c_start();
    wbyte(dev(1'b1), a2);
    check({req, " read acks"}, {a0, a1, a2}, 3'b111);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, b);
      rd_buf[i] = b;
    end
    i2c_stop();
    check("R9 sda released after stop", sda_oe, 0);
    for (int i = 0; i < n; i++)
      check(req, rd_buf[i], model[8'(p + 8'(i))]);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b, p, d, wa;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 3'b101;
    load_we = 1'b0; load_addr = '0; load_data = '0;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    waitq(2);

    // R8: reset state
    check("R8 sda_oe after reset", sda_oe, 0);
    check("R8 csum_err after reset", csum_err, 0);
    bus_read(8'd77, 2, "R8 cleared byte");

    // R6/R7: load an image over the parallel port
    for (int i = 0; i < 256; i++) model[i] = 8'($urandom);
    model[0] = 8'h80; model[1] = 8'h08; model[2] = 8'h07;
    model[63] = model_sum();
    for (int i = 0; i < 256; i++) load(8'(i), model[i]);
    check("R6 image sum matches", csum_err, 0);
    load(8'd5, model[5] + 8'd1);
    check("R6 low byte changed", csum_err, 1);
    load(8'd5, model[5]);
    check("R6 low byte restored", csum_err, 0);
    load(8'd62, model[62] ^ 8'h40);
    check("R6 byte 62 changed", csum_err, 1);
    load(8'd62, model[62]);
    load(8'd200, model[200] ^ 8'hFF);
    model[200] = model[200] ^ 8'hFF;
    check("R6 upper byte outside sum", csum_err, 0);
    load(8'd63, model[63] + 8'd3);
    check("R6 checksum byte wrong", csum_err, 1);
    load(8'd63, model[63]);
    check("R6 checksum byte restored", csum_err, 0);
    bus_read(8'd0, 4, "R7 loaded locked bytes");

    // R1: foreign addresses are not acknowledged
    for (int k = 0; k < 6; k++) begin
      do wa = {7'($urandom), 1'b0}; while (wa[7:1] == {4'b1010, strap});
      i2c_start();
      wbyte(wa, ack);
      check("R1 foreign address nack", ack, 0);
      wbyte(8'h90, ack);
      check("R1 ignored pointer byte", ack, 0);
      wbyte(8'h5A, ack);
      i2c_stop();
    end
    bus_read(8'h90, 1, "R1 ignored write");

    // R2: locked byte
    bus_write(8'd20, ~model[20], "R2 locked");
    bus_read(8'd20, 1, "R2 locked byte unchanged");
    bus_write(8'd127, ~model[127], "R2 locked top");
    bus_read(8'd127, 1, "R2 byte 127 unchanged");
    check("R2 checksum intact", csum_err, 0);

    // R3/R4/R5: random traffic
    for (int k = 0; k < 24; k++) begin
      p = {1'b1, 7'($urandom)};
      d = 8'($urandom);
      bus_write(p, d, "R3 upper");
      bus_read(p, 1, "R3 upper readback");
      bus_read(8'($urandom), 1 + int'($urandom % 3), "R4 random read");
    end

    // R5: sequential write and read across the wrap
    i2c_start();
    wbyte(dev(1'b0), ack);
    wbyte(8'd254, ack);
    for (int i = 0; i < 4; i++) begin
      d = 8'($urandom);
      wbyte(d, ack);
      check("R5 sequential write ack", ack, 1);
      if (i < 2) model[8'd254 + 8'(i)] = d;
    end
    i2c_stop();
    bus_read(8'd254, 4, "R5 wrap read");
    bus_read(8'd250, 8, "R5 long sequential read");

    // R7: load and bus write collide on one byte
    collide_addr = 8'd150; collide_data = 8'hC3;
    i2c_start();
    wbyte(dev(1'b0), ack);
    wbyte(8'd150, ack);
    collide_arm = 1'b1;
    wbyte(8'h3C, ack);
    collide_arm = 1'b0;
    i2c_stop();
    check("R7 collision ack", ack, 1);
    model[150] = 8'hC3;
    bus_read(8'd150, 1, "R7 load kept on collision");

    // R9/R4: stop after pointer, then current-address read
    i2c_start();
    wbyte(dev(1'b0), ack);
    wbyte(8'hA0, ack);
    i2c_stop();
    check("R9 idle after aborted write", sda_oe, 0);
    i2c_start();
    wbyte(dev(1'b1), ack);
    check("R4 current read ack", ack, 1);
    rbyte(1'b1, b);
    i2c_stop();
    check("R4 current-pointer read", b, model[8'hA0]);

    // R1: new strap value moves the address
    wa = dev(1'b0);
    strap = 3'b010;
    waitq(4);
    i2c_start();
    wbyte(wa, ack);
    i2c_stop();
    check("R1 old strap address nack", ack, 0);
    bus_read(8'd33, 2, "R1 new strap address");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule